// File: doc/BRIEF.md
# Operand-Wakeup Scheduling Window

This block is a small scheduling window placed between an upstream rename stage and one functional unit. Each slot holds one renamed operation: an opcode, a destination tag, and two source operands. Each source is either already a value, or still waiting for the tag of the operation that will produce it. The window watches a single result bus. Whenever a result appears, every waiting source whose tag equals the bus tag takes the value and becomes ready.

Once both sources of a slot are ready, the slot can be issued. Each cycle at most one such slot is sent to the functional unit, and the one chosen is the oldest by insertion order. Younger independent work therefore overtakes older work that is still stalled. The issued slot is released in the same cycle.

Upstream offers an operation with a valid/ready pair and holds it until it is taken. A flush input empties the window in one cycle.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset the window is empty: `insReady` is 1 and `issValid` is 0.
- R2: An operation inserted with both sources ready is presented on the issue outputs in the cycle after it is accepted. The outputs carry its opcode, destination tag and both stored values.
- R3: A result (`bcValid`=1) whose `bcTag` equals a waiting source's tag makes that source ready and stores `bcVal` as its value. The slot can issue from the cycle after the result.
- R4: A source that is already ready keeps its value when a result appears with a tag equal to that source's tag field.
- R5: If a result appears in the same cycle as an insertion, any waiting source of the inserted operation whose tag matches captures the result value. That wakeup is not lost.
- R6: A slot with at least one waiting source is never issued.
- R7: A younger operation whose sources are ready issues before an older operation that is still waiting.
- R8: When several slots are ready, the one inserted earliest issues first, whatever slot position it occupies.
- R9: At most one operation issues per cycle. The issued slot is free for a new insertion from the next cycle.
- R10: With all 8 slots occupied, `insReady` is 0. An operation offered while `insReady` is 0 is not taken, and it is taken once a slot frees.
- R11: In a cycle with `flush`=1, `issValid` is 0 and no insertion is taken. Afterwards all slots are empty and former contents never issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty every slot this cycle |
| insValid | input | 1 | Upstream offers an operation |
| insReady | output | 1 | A free slot exists; the offer is taken at this edge |
| insOp | input | OP_W | Opcode of the offered operation |
| insDst | input | TAG_W | Destination tag of the offered operation |
| insARdy | input | 1 | Source A already holds a value |
| insATag | input | TAG_W | Producer tag of source A |
| insAVal | input | DATA_W | Value of source A when ready |
| insBRdy | input | 1 | Source B already holds a value |
| insBTag | input | TAG_W | Producer tag of source B |
| insBVal | input | DATA_W | Value of source B when ready |
| bcValid | input | 1 | Result bus carries a result this cycle |
| bcTag | input | TAG_W | Tag of the result |
| bcVal | input | DATA_W | Value of the result |
| issValid | output | 1 | An operation is issued this cycle |
| issOp | output | OP_W | Opcode of the issued operation |
| issDst | output | TAG_W | Destination tag of the issued operation |
| issA | output | DATA_W | Source A value of the issued operation |
| issB | output | DATA_W | Source B value of the issued operation |

## Verification
The hardest case to reach from the ports is oldest-first selection where the older ready slot sits at a higher slot position than a younger ready slot. A position-based priority would pass every simpler test.

The stimulus builds this case on purpose:
1. Insert two waiting operations.
2. Wake and drain the first, which frees the lowest slot.
3. Insert a third operation into that freed slot, waiting on the same tag as the second.
4. Broadcast that one tag, so both become ready in the same cycle.

A full window with a held ninth offer is also driven, and it drains while the offer waits. This covers back-pressure and slot reuse together.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int ENT_N = 8;
  localparam int IDX_W = $clog2(ENT_N);

  // strobes from control to datapath, one-hot per slot
  typedef struct packed {
    logic [ENT_N-1:0] insOh;
    logic [ENT_N-1:0] issOh;
  } rsw_strb_t;
endpackage

// File: rtl/rsw_ctrl.sv
module rsw_ctrl
  import rsw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             insValid,
  input  logic [ENT_N-1:0] eligVec,
  output logic             insReady,
  output logic             issValid,
  output logic [ENT_N-1:0] validVec,
  output rsw_strb_t        strb
);
  logic [ENT_N-1:0] validQ;
  logic [IDX_W-1:0] ageQ [ENT_N];
  logic [ENT_N-1:0] freeOh;
  logic [ENT_N-1:0] pickOh;
  logic [ENT_N-1:0] readyVec;
  logic [IDX_W-1:0] pickAge;
  logic             pickFound;
  logic [IDX_W:0]   occCnt;
  logic [IDX_W:0]   newAgeW;

  assign readyVec = validQ & eligVec;
  assign validVec = validQ;

  // lowest free slot
  always_comb begin
    freeOh = '0;
    for (int i = ENT_N - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeOh    = '0;
        freeOh[i] = 1'b1;
      end
    end
  end

  // oldest ready slot: ages are dense ranks, smallest is oldest
  always_comb begin
    pickOh    = '0;
    pickAge   = '1;
    pickFound = 1'b0;
    for (int i = 0; i < ENT_N; i++) begin
      if (readyVec[i] && (!pickFound || ageQ[i] < pickAge)) begin
        pickFound = 1'b1;
        pickAge   = ageQ[i];
        pickOh    = '0;
        pickOh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    occCnt = '0;
    for (int i = 0; i < ENT_N; i++) begin
      occCnt = occCnt + {{IDX_W{1'b0}}, validQ[i]};
    end
  end

  assign insReady   = |(~validQ);
  assign issValid   = pickFound & ~flush;
  assign strb.insOh = (insValid && insReady && !flush) ? freeOh : '0;
  assign strb.issOh = flush ? '0 : pickOh;
  assign newAgeW    = occCnt - {{IDX_W{1'b0}}, issValid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENT_N; i++) ageQ[i] <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENT_N; i++) begin
        if (strb.insOh[i]) begin
          validQ[i] <= 1'b1;
          ageQ[i]   <= newAgeW[IDX_W-1:0];
        end else if (strb.issOh[i]) begin
          validQ[i] <= 1'b0;
        end else if (validQ[i] && issValid && ageQ[i] > pickAge) begin
          ageQ[i] <= ageQ[i] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsw_data.sv
module rsw_data
  import rsw_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsw_strb_t         strb,
  input  logic [OP_W-1:0]   insOp,
  input  logic [TAG_W-1:0]  insDst,
  input  logic              insARdy,
  input  logic [TAG_W-1:0]  insATag,
  input  logic [DATA_W-1:0] insAVal,
  input  logic              insBRdy,
  input  logic [TAG_W-1:0]  insBTag,
  input  logic [DATA_W-1:0] insBVal,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcVal,
  output logic [ENT_N-1:0]  eligVec,
  output logic [OP_W-1:0]   issOp,
  output logic [TAG_W-1:0]  issDst,
  output logic [DATA_W-1:0] issA,
  output logic [DATA_W-1:0] issB
);
  logic [OP_W-1:0]   opArr  [ENT_N];
  logic [TAG_W-1:0]  dstArr [ENT_N];
  logic [DATA_W-1:0] aArr   [ENT_N];
  logic [DATA_W-1:0] bArr   [ENT_N];

  // insert-time snoop so a result in the insert cycle is not missed
  logic insAHit, insBHit;
  assign insAHit = !insARdy && bcValid && (bcTag == insATag);
  assign insBHit = !insBRdy && bcValid && (bcTag == insBTag);

  for (genvar g = 0; g < ENT_N; g++) begin : gSlot
    logic [OP_W-1:0]   opQ;
    logic [TAG_W-1:0]  dstQ;
    logic              aRdyQ, bRdyQ;
    logic [TAG_W-1:0]  aTagQ, bTagQ;
    logic [DATA_W-1:0] aValQ, bValQ;
    logic              aHit, bHit;

    assign aHit = !aRdyQ && bcValid && (bcTag == aTagQ);
    assign bHit = !bRdyQ && bcValid && (bcTag == bTagQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opQ   <= '0;
        dstQ  <= '0;
        aRdyQ <= 1'b0;
        bRdyQ <= 1'b0;
        aTagQ <= '0;
        bTagQ <= '0;
        aValQ <= '0;
        bValQ <= '0;
      end else if (strb.insOh[g]) begin
        opQ   <= insOp;
        dstQ  <= insDst;
        aTagQ <= insATag;
        bTagQ <= insBTag;
        aRdyQ <= insARdy | insAHit;
        bRdyQ <= insBRdy | insBHit;
        aValQ <= insAHit ? bcVal : insAVal;
        bValQ <= insBHit ? bcVal : insBVal;
      end else begin
        if (aHit) begin
          aRdyQ <= 1'b1;
          aValQ <= bcVal;
        end
        if (bHit) begin
          bRdyQ <= 1'b1;
          bValQ <= bcVal;
        end
      end
    end

    assign eligVec[g] = aRdyQ & bRdyQ;
    assign opArr[g]   = opQ;
    assign dstArr[g]  = dstQ;
    assign aArr[g]    = aValQ;
    assign bArr[g]    = bValQ;
  end

  // one-hot OR mux toward the functional unit
  always_comb begin
    issOp  = '0;
    issDst = '0;
    issA   = '0;
    issB   = '0;
    for (int i = 0; i < ENT_N; i++) begin
      if (strb.issOh[i]) begin
        issOp  = issOp  | opArr[i];
        issDst = issDst | dstArr[i];
        issA   = issA   | aArr[i];
        issB   = issB   | bArr[i];
      end
    end
  end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select
  import rsw_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              insValid,
  output logic              insReady,
  input  logic [OP_W-1:0]   insOp,
  input  logic [TAG_W-1:0]  insDst,
  input  logic              insARdy,
  input  logic [TAG_W-1:0]  insATag,
  input  logic [DATA_W-1:0] insAVal,
  input  logic              insBRdy,
  input  logic [TAG_W-1:0]  insBTag,
  input  logic [DATA_W-1:0] insBVal,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcVal,
  output logic              issValid,
  output logic [OP_W-1:0]   issOp,
  output logic [TAG_W-1:0]  issDst,
  output logic [DATA_W-1:0] issA,
  output logic [DATA_W-1:0] issB
);
  rsw_strb_t        strb;
  logic [ENT_N-1:0] eligVec;
  logic [ENT_N-1:0] validVec;

  rsw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .insValid (insValid),
    .eligVec  (eligVec),
    .insReady (insReady),
    .issValid (issValid),
    .validVec (validVec),
    .strb     (strb)
  );

  rsw_data #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W),
    .OP_W   (OP_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .insOp   (insOp),
    .insDst  (insDst),
    .insARdy (insARdy),
    .insATag (insATag),
    .insAVal (insAVal),
    .insBRdy (insBRdy),
    .insBTag (insBTag),
    .insBVal (insBVal),
    .bcValid (bcValid),
    .bcTag   (bcTag),
    .bcVal   (bcVal),
    .eligVec (eligVec),
    .issOp   (issOp),
    .issDst  (issDst),
    .issA    (issA),
    .issB    (issB)
  );
endmodule

// File: rtl/rs_wakeup_select_chk.sv
module rs_wakeup_select_chk
  import rsw_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             insValid,
  input logic             insReady,
  input logic             issValid,
  input logic [ENT_N-1:0] validVec,
  input logic [ENT_N-1:0] eligVec,
  input logic [ENT_N-1:0] issOh
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issOh)); // R9

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (issOh & ~(validVec & eligVec)) == '0); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0)); // R11

  AST_FLUSH_NO_ISSUE_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !issValid); // R11

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insReady && !issValid && !flush) |=> $stable(validVec)); // R10

  AST_INSERT_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insReady && !issValid && !flush)
      |=> ($countones(validVec) == $past($countones(validVec)) + 1)); // R2

  AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !(insValid && insReady))
      |=> ($countones(validVec) == $past($countones(validVec)) - 1)); // R9
endmodule

bind rs_wakeup_select rs_wakeup_select_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flush    (flush),
  .insValid (insValid),
  .insReady (insReady),
  .issValid (issValid),
  .validVec (validVec),
  .eligVec  (eligVec),
  .issOh    (strb.issOh)
);

// File: tb/rs_wakeup_select_tb.sv
module rs_wakeup_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int OP_W   = 6;

  logic clk = 1'b0;
  logic rstN, flush, insValid, insReady;
  logic [OP_W-1:0] insOp;
  logic [TAG_W-1:0] insDst, insATag, insBTag, bcTag;
  logic insARdy, insBRdy, bcValid;
  logic [DATA_W-1:0] insAVal, insBVal, bcVal;
  logic issValid;
  logic [OP_W-1:0] issOp;
  logic [TAG_W-1:0] issDst;
  logic [DATA_W-1:0] issA, issB;

  typedef struct {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  dst;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    string             req;
  } exp_t;

  exp_t expQ[$];
  int   errCnt = 0;
  int   chkCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_wakeup_select #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .insValid(insValid), .insReady(insReady), .insOp(insOp), .insDst(insDst),
    .insARdy(insARdy), .insATag(insATag), .insAVal(insAVal),
    .insBRdy(insBRdy), .insBTag(insBTag), .insBVal(insBVal),
    .bcValid(bcValid), .bcTag(bcTag), .bcVal(bcVal),
    .issValid(issValid), .issOp(issOp), .issDst(issDst), .issA(issA), .issB(issB)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic expectIss(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                           input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                           input string req);
    exp_t e;
    e.op = op; e.dst = dst; e.a = a; e.b = b; e.req = req;
    expQ.push_back(e);
  endtask

  // called just after a falling edge; returns just after the falling edge following acceptance
  task automatic ins(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                     input bit ra, input logic [TAG_W-1:0] ta, input logic [DATA_W-1:0] va,
                     input bit rb, input logic [TAG_W-1:0] tb, input logic [DATA_W-1:0] vb);
    insValid = 1'b1; insOp = op; insDst = dst;
    insARdy = ra; insATag = ta; insAVal = va;
    insBRdy = rb; insBTag = tb; insBVal = vb;
    while (!insReady) @(negedge clk);
    @(negedge clk);
    insValid = 1'b0;
  endtask

  task automatic bc(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val);
    bcValid = 1'b1; bcTag = tag; bcVal = val;
    @(negedge clk);
    bcValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
  endtask

  // monitor / scoreboard: samples one step after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN === 1'b1 && issValid === 1'b1) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R6", $sformatf("unexpected issue op=%0h dst=%0h a=%0h b=%0h, expected no issue",
                                    issOp, issDst, issA, issB));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(issOp == e.op && issDst == e.dst && issA == e.a && issB == e.b, e.req,
              $sformatf("issue actual op=%0h dst=%0h a=%0h b=%0h expected op=%0h dst=%0h a=%0h b=%0h",
                        issOp, issDst, issA, issB, e.op, e.dst, e.a, e.b));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; flush = 1'b0; insValid = 1'b0; bcValid = 1'b0;
    insOp = '0; insDst = '0; insARdy = 1'b0; insATag = '0; insAVal = '0;
    insBRdy = 1'b0; insBTag = '0; insBVal = '0; bcTag = '0; bcVal = '0;
    idle(3);
    rstN = 1'b1;
    #1;
    chk(insReady == 1'b1, "R1", $sformatf("insReady actual %0b expected 1", insReady));
    chk(issValid == 1'b0, "R1", $sformatf("issValid actual %0b expected 0", issValid));
    @(negedge clk);

    // R2: ready-at-insert operations issue on the next cycle
    expectIss(6'h01, 4'h1, 32'h11, 32'h22, "R2");
    expectIss(6'h02, 4'h2, 32'h33, 32'h44, "R2");
    ins(6'h01, 4'h1, 1, 4'h0, 32'h11, 1, 4'h0, 32'h22);
    ins(6'h02, 4'h2, 1, 4'h0, 32'h33, 1, 4'h0, 32'h44);
    idle(3);

    // R7 then R3: younger ready goes first, older wakes on tag 5
    expectIss(6'h04, 4'h4, 32'h44, 32'h45, "R7");
    expectIss(6'h03, 4'h3, 32'hA5A5, 32'h33, "R3");
    ins(6'h03, 4'h3, 0, 4'h5, 32'h0, 1, 4'h0, 32'h33);
    ins(6'h04, 4'h4, 1, 4'h0, 32'h44, 1, 4'h0, 32'h45);
    idle(2);
    #1;
    chk(issValid == 1'b0, "R6", $sformatf("waiting slot issValid actual %0b expected 0", issValid));
    @(negedge clk);
    bc(4'h5, 32'hA5A5);
    idle(3);

    // R8: older slot at a higher position beats younger slot at position 0
    expectIss(6'h05, 4'h5, 32'h80, 32'h1, "R3");
    ins(6'h05, 4'h5, 0, 4'h8, 32'h0, 1, 4'h0, 32'h1);
    ins(6'h06, 4'h6, 0, 4'h9, 32'h0, 1, 4'h0, 32'h2);
    bc(4'h8, 32'h80);
    idle(2);
    ins(6'h07, 4'h7, 0, 4'h9, 32'h0, 1, 4'h0, 32'h3);
    expectIss(6'h06, 4'h6, 32'h90, 32'h2, "R8");
    expectIss(6'h07, 4'h7, 32'h90, 32'h3, "R8");
    bc(4'h9, 32'h90);
    idle(4);

    // R5: result arrives in the insert cycle on both sources
    expectIss(6'h08, 4'h8, 32'hC0DE, 32'hC0DE, "R5");
    insValid = 1'b1; insOp = 6'h08; insDst = 4'h8;
    insARdy = 1'b0; insATag = 4'hA; insAVal = 32'h0;
    insBRdy = 1'b0; insBTag = 4'hA; insBVal = 32'h0;
    bcValid = 1'b1; bcTag = 4'hA; bcVal = 32'hC0DE;
    @(negedge clk);
    insValid = 1'b0; bcValid = 1'b0;
    idle(3);

    // R4: a ready source ignores a result carrying its tag field
    expectIss(6'h09, 4'h9, 32'h111, 32'h222, "R4");
    ins(6'h09, 4'h9, 1, 4'hB, 32'h111, 0, 4'hC, 32'h0);
    bc(4'hB, 32'hBAD);
    idle(1);
    bc(4'hC, 32'h222);
    idle(3);

    // R10 / R9: fill all slots, hold a ninth offer, drain one per cycle
    for (int i = 0; i < 8; i++) begin
      expectIss(6'h10 + 6'(i), 4'(i), 32'hD00D, 32'(i), "R8");
      ins(6'h10 + 6'(i), 4'(i), 0, 4'hD, 32'h0, 1, 4'h0, 32'(i));
    end
    #1;
    chk(insReady == 1'b0, "R10", $sformatf("full insReady actual %0b expected 0", insReady));
    @(negedge clk);
    expectIss(6'h1E, 4'hF, 32'h9, 32'h9, "R10");
    fork
      ins(6'h1E, 4'hF, 1, 4'h0, 32'h9, 1, 4'h0, 32'h9);
      begin
        idle(3);
        bc(4'hD, 32'hD00D);
      end
    join
    idle(12);
    chk(expQ.size() == 0, "R9", $sformatf("pending after drain actual %0d expected 0", expQ.size()));

    // R11: flush a full window with an insert offered in the flush cycle
    for (int i = 0; i < 8; i++) begin
      ins(6'h20 + 6'(i), 4'(i), 0, 4'hE, 32'h0, 1, 4'h0, 32'h0);
    end
    flush = 1'b1;
    insValid = 1'b1; insOp = 6'h2F; insDst = 4'h1;
    insARdy = 1'b1; insAVal = 32'h5; insBRdy = 1'b1; insBVal = 32'h6;
    @(negedge clk);
    flush = 1'b0; insValid = 1'b0;
    #1;
    chk(insReady == 1'b1, "R11", $sformatf("after flush insReady actual %0b expected 1", insReady));
    @(negedge clk);
    bc(4'hE, 32'h77);
    idle(3);

    // R11: flush in the cycle a ready slot would issue
    ins(6'h2A, 4'h2, 1, 4'h0, 32'h1, 1, 4'h0, 32'h2);
    flush = 1'b1;
    #1;
    chk(issValid == 1'b0, "R11", $sformatf("flush-cycle issValid actual %0b expected 0", issValid));
    @(negedge clk);
    flush = 1'b0;
    idle(3);

    // window still usable after flush
    expectIss(6'h29, 4'h3, 32'h31, 32'h32, "R11");
    ins(6'h29, 4'h3, 1, 4'h0, 32'h31, 1, 4'h0, 32'h32);
    idle(4);
    chk(expQ.size() == 0, "R2", $sformatf("pending at end actual %0d expected 0", expQ.size()));

    summary();
    $finish;
  end
endmodule